// File: doc/BRIEF.md
# Timer Event Flag Controller

This block keeps the sticky event flags of a timer. There is one flag for counter overflow and one flag for each channel. A one-cycle strobe from the timer sets the matching flag. For a channel, the strobe is a compare match or a captured edge. A set flag stays set until software clears it on purpose.

Clearing takes two register accesses. First, a read of the flag register arms every flag that reads back as 1. Then a write of 0 to an armed bit clears it. A new event for a flag cancels its arming, so the event is never lost. Each flag has its own interrupt enable. The interrupt request is a registered level equal to the OR of all enabled flags.

Flag bit 0 is the overflow flag. Bit k+1 is channel k. The write strobe carries a per-bit mask, so only the selected bits take part in a write.

Top module: `tef_flag_ctrl`

## Requirements
- R1: A strobe on `ovf_evt` sets `flags[0]`, and a strobe on `ch_evt[k]` sets `flags[k+1]`. The flag reads as 1 from the clock edge that samples the strobe.
- R2: A flag clears at a write edge when `wr_stb` is high, its `wr_mask` bit is 1, its `wr_data` bit is 0, and an earlier `rd_stb` cycle saw the flag at 1 and armed it.
- R3: A write of 0 to a flag that has not been armed leaves the flag at 1. A read taken while the flag is 0 does not arm it.
- R4: An event for an armed flag cancels the arming. The next write of 0 leaves the flag set, and a fresh read is needed before the flag can be cleared.
- R5: When an event and a valid clearing write for the same flag fall in one cycle, the event wins. The flag stays 1 and is no longer armed.
- R6: The following leave a flag and its arming unchanged: a write with the flag's `wr_data` bit at 1, and a write with its `wr_mask` bit at 0.
- R7: `irq` is registered. After each edge it equals the OR over all bits of (flag after that edge AND `int_en` sampled at that edge). It stays high as long as any enabled flag is set.
- R8: Reset clears all flags, all arming state and `irq`. A write of 0 after reset does not clear a flag that was set again before any read.
- R9: Flags act independently. One read arms every flag that is set at that moment, and a clear on one bit does not touch the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 1 | Counter overflow strobe |
| ch_evt | input | NCH | Channel match/capture strobes |
| rd_stb | input | 1 | Flag register read strobe |
| wr_stb | input | 1 | Flag register write strobe |
| wr_mask | input | NCH+1 | Bits taking part in the write |
| wr_data | input | NCH+1 | Write data, 0 requests a clear |
| int_en | input | NCH+1 | Per-flag interrupt enables |
| flags | output | NCH+1 | Current flag values |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the windows where the clear sequence can go wrong. These are:
- A write of 0 with no read before it. A design that treated any write of 0 as a clear would drop flags.
- An event between the read and the write. A design that kept the arming would lose the event.
- An event in the same cycle as the clearing write. Here a wrong priority clears the flag.

The bench also checks that writes with the data bit at 1 or the mask bit at 0 change nothing. It runs a long pseudo-random sweep over all four flags against an arithmetic model, which exposes any crosstalk between bits and an `irq` that lags or leads the flags.

// File: rtl/tef_pkg.sv
package tef_pkg;
  // Per-flag request decoded from the register and event strobes
  typedef struct packed {
    logic set;   // event recognized this cycle
    logic rd;    // flag register read
    logic wr0;   // write of 0 to this bit
  } tef_req_t;
endpackage

// File: rtl/tef_req_decode.sv
module tef_req_decode
  import tef_pkg::*;
#(
  parameter int NCH = 4,
  localparam int NF = NCH + 1
) (
  input  logic           ovf_evt,
  input  logic [NCH-1:0] ch_evt,
  input  logic           rd_stb,
  input  logic           wr_stb,
  input  logic [NF-1:0]  wr_mask,
  input  logic [NF-1:0]  wr_data,
  output tef_req_t       req [NF]
);
  logic [NF-1:0] evt_vec;
  assign evt_vec = {ch_evt, ovf_evt};

  for (genvar i = 0; i < NF; i++) begin : g_dec
    always_comb begin
      req[i].set = evt_vec[i];
      req[i].rd  = rd_stb;
      req[i].wr0 = wr_stb & wr_mask[i] & ~wr_data[i];
    end
  end
endmodule

// File: rtl/tef_flag_cell.sv
module tef_flag_cell
  import tef_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tef_req_t req,
  output logic     flag_q,
  output logic     flag_nxt,
  output logic     arm_q
);
  logic arm_nxt;

  always_comb begin
    flag_nxt = flag_q;
    arm_nxt  = arm_q;
    if (req.set) begin
      flag_nxt = 1'b1;
      arm_nxt  = 1'b0;
    end else if (req.wr0) begin
      if (arm_q) flag_nxt = 1'b0;
      arm_nxt = 1'b0;
    end else if (req.rd && flag_q) begin
      arm_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      arm_q  <= arm_nxt;
    end
  end

  a_r1_event_sets: assert property (@(posedge clk) disable iff (rst)
    req.set |=> flag_q);
  a_r2_armed_clear: assert property (@(posedge clk) disable iff (rst)
    (arm_q && req.wr0 && !req.set) |=> !flag_q);
  a_r3_unarmed_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !arm_q && !req.set) |=> flag_q);
  a_r4_event_disarms: assert property (@(posedge clk) disable iff (rst)
    (arm_q && req.set) |=> (flag_q && !arm_q));
  a_r8_arm_implies_flag: assert property (@(posedge clk) disable iff (rst)
    arm_q |-> flag_q);
endmodule

// File: rtl/tef_irq_merge.sv
module tef_irq_merge #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flag_nxt,
  input  logic [NF-1:0] int_en,
  output logic          irq
);
  logic any_en;
  assign any_en = |(flag_nxt & int_en);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any_en;
  end
endmodule

// File: rtl/tef_flag_ctrl.sv
module tef_flag_ctrl
  import tef_pkg::*;
#(
  parameter int NCH = 4,
  localparam int NF = NCH + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ovf_evt,
  input  logic [NCH-1:0] ch_evt,
  input  logic           rd_stb,
  input  logic           wr_stb,
  input  logic [NF-1:0]  wr_mask,
  input  logic [NF-1:0]  wr_data,
  input  logic [NF-1:0]  int_en,
  output logic [NF-1:0]  flags,
  output logic           irq
);
  tef_req_t      req [NF];
  logic [NF-1:0] flag_nxt;
  logic [NF-1:0] arm;

  tef_req_decode #(.NCH(NCH)) u_dec (
    .ovf_evt (ovf_evt),
    .ch_evt  (ch_evt),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .req     (req)
  );

  for (genvar i = 0; i < NF; i++) begin : g_cell
    tef_flag_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .req      (req[i]),
      .flag_q   (flags[i]),
      .flag_nxt (flag_nxt[i]),
      .arm_q    (arm[i])
    );
  end

  tef_irq_merge #(.NF(NF)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .flag_nxt (flag_nxt),
    .int_en   (int_en),
    .irq      (irq)
  );

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & $past(int_en)));
  a_r9_wr1_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !ovf_evt && wr_mask[0] && wr_data[0]) |=> flags[0] == $past(flags[0]));
  a_r8_arm_subset: assert property (@(posedge clk) disable iff (rst)
    (arm & ~flags) == '0);
endmodule

// File: tb/tb_tef_flag_ctrl.sv
module tb_tef_flag_ctrl;
  localparam int NCH = 3;
  localparam int NF  = NCH + 1;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic ovf_evt;
  logic [NCH-1:0] ch_evt;
  logic rd_stb, wr_stb;
  logic [NF-1:0] wr_mask, wr_data, int_en;
  logic [NF-1:0] flags;
  logic irq;

  int total = 0;
  int bad = 0;

  logic [NF-1:0] m_flag, m_arm;
  logic m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tef_flag_ctrl #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .ch_evt(ch_evt),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_mask(wr_mask), .wr_data(wr_data),
    .int_en(int_en), .flags(flags), .irq(irq)
  );

  task automatic chk(input string tag, input logic [NF-1:0] ef, input logic ei);
    total++;
    if (flags !== ef || irq !== ei) begin
      bad++;
      $display("FAIL %s flags=%b irq=%b expected flags=%b irq=%b", tag, flags, irq, ef, ei);
    end
  endtask

  // one clock: drive at negedge, model from the rules, compare at next negedge
  task automatic cyc(input string tag, input logic ov, input logic [NCH-1:0] ch,
                     input logic rd, input logic wr, input logic [NF-1:0] m,
                     input logic [NF-1:0] d, input logic [NF-1:0] en);
    logic [NF-1:0] ev, nf, na;
    ovf_evt = ov; ch_evt = ch; rd_stb = rd; wr_stb = wr;
    wr_mask = m; wr_data = d; int_en = en;
    ev = {ch, ov};
    for (int i = 0; i < NF; i++) begin
      nf[i] = m_flag[i]; na[i] = m_arm[i];
      if (ev[i]) begin nf[i] = 1'b1; na[i] = 1'b0; end
      else if (wr && m[i] && !d[i]) begin
        if (m_arm[i]) nf[i] = 1'b0;
        na[i] = 1'b0;
      end else if (rd && m_flag[i]) na[i] = 1'b1;
    end
    @(posedge clk);
    m_flag = nf; m_arm = na; m_irq = |(nf & en);
    @(negedge clk);
    ovf_evt = 0; ch_evt = '0; rd_stb = 0; wr_stb = 0;
    chk(tag, m_flag, m_irq);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_flag = '0; m_arm = '0; m_irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; ovf_evt = 0; ch_evt = '0; rd_stb = 0; wr_stb = 0;
    wr_mask = '0; wr_data = '0; int_en = '0;
    @(negedge clk);
    do_reset();
    chk("R8 reset state", 4'b0000, 1'b0);

    // R1: each source sets its own bit
    cyc("R1 ovf", 1, 3'b000, 0, 0, '0, '0, '0);
    chk("R1 ovf bit0", 4'b0001, 1'b0);
    cyc("R1 ch1", 0, 3'b010, 0, 0, '0, '0, '0);
    chk("R1 ch1 bit2", 4'b0101, 1'b0);

    // R3: write 0 without read keeps flags
    cyc("R3 unarmed wr0", 0, 3'b000, 0, 1, 4'b1111, 4'b0000, '0);
    chk("R3 unarmed wr0", 4'b0101, 1'b0);

    // R2 + R9: read arms both, clear only bit0
    cyc("R2 read", 0, 3'b000, 1, 0, '0, '0, '0);
    cyc("R9 clear bit0", 0, 3'b000, 0, 1, 4'b0001, 4'b0000, '0);
    chk("R9 clear bit0 only", 4'b0100, 1'b0);
    cyc("R2 clear bit2", 0, 3'b000, 0, 1, 4'b0100, 4'b0000, '0);
    chk("R2 clear bit2", 4'b0000, 1'b0);

    // R3: read while clear does not arm
    cyc("R3 read clear", 0, 3'b000, 1, 0, '0, '0, '0);
    cyc("R3 set ch2", 0, 3'b100, 0, 0, '0, '0, '0);
    cyc("R3 wr0 after stale read", 0, 3'b000, 0, 1, 4'b1000, 4'b0000, '0);
    chk("R3 stale read no arm", 4'b1000, 1'b0);

    // R4: event between read and write
    cyc("R4 read", 0, 3'b000, 1, 0, '0, '0, '0);
    cyc("R4 event", 0, 3'b100, 0, 0, '0, '0, '0);
    cyc("R4 wr0", 0, 3'b000, 0, 1, 4'b1000, 4'b0000, '0);
    chk("R4 flag kept", 4'b1000, 1'b0);
    cyc("R4 reread", 0, 3'b000, 1, 0, '0, '0, '0);
    cyc("R4 wr0 again", 0, 3'b000, 0, 1, 4'b1000, 4'b0000, '0);
    chk("R4 cleared after reread", 4'b0000, 1'b0);

    // R5: event same cycle as clearing write
    cyc("R5 set", 1, 3'b000, 0, 0, '0, '0, '0);
    cyc("R5 read", 0, 3'b000, 1, 0, '0, '0, '0);
    cyc("R5 race", 1, 3'b000, 0, 1, 4'b0001, 4'b0000, '0);
    chk("R5 event wins", 4'b0001, 1'b0);
    cyc("R5 wr0 disarmed", 0, 3'b000, 0, 1, 4'b0001, 4'b0000, '0);
    chk("R5 no longer armed", 4'b0001, 1'b0);

    // R6: write 1 and masked-off bit keep flag and arming
    cyc("R6 read", 0, 3'b000, 1, 0, '0, '0, '0);
    cyc("R6 wr1", 0, 3'b000, 0, 1, 4'b0001, 4'b0001, '0);
    chk("R6 wr1 keeps flag", 4'b0001, 1'b0);
    cyc("R6 masked wr0", 0, 3'b000, 0, 1, 4'b1110, 4'b0000, '0);
    chk("R6 masked keeps flag", 4'b0001, 1'b0);
    cyc("R6 arm kept", 0, 3'b000, 0, 1, 4'b0001, 4'b0000, '0);
    chk("R6 arming survived", 4'b0000, 1'b0);

    // R7: irq level with enables
    cyc("R7 set ch0 en", 0, 3'b001, 0, 0, '0, '0, 4'b0010);
    chk("R7 irq with flag", 4'b0010, 1'b1);
    cyc("R7 hold", 0, 3'b000, 0, 0, '0, '0, 4'b0010);
    chk("R7 irq held", 4'b0010, 1'b1);
    cyc("R7 disable", 0, 3'b000, 0, 0, '0, '0, 4'b1101);
    chk("R7 irq off when disabled", 4'b0010, 1'b0);

    // R8: reset mid-sequence drops arming
    cyc("R8 read", 0, 3'b000, 1, 0, '0, '0, '0);
    do_reset();
    chk("R8 reset clears", 4'b0000, 1'b0);
    cyc("R8 set", 0, 3'b001, 0, 0, '0, '0, 4'b1111);
    cyc("R8 wr0", 0, 3'b000, 0, 1, 4'b0010, 4'b0000, 4'b1111);
    chk("R8 no stale arm", 4'b0010, 1'b1);

    // R9: pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      cyc("R9 sweep", r[0] & r[1], {r[2] & r[3], r[4] & r[5], r[6] & r[7]},
          r[8], r[9], r[13:10], {r[14], r[15] & r[0], r[3], r[5] & r[6]},
          {r[1], r[7], r[12], r[15]});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule